// File: doc/BRIEF.md
# At-Speed Capture Clock Pulse Filter

This block gates a functional clock so that, during transition-fault scan testing, a short and exactly placed burst of functional-speed pulses reaches the logic under test. While scan enable is high the block is in shift mode and passes no pulses. When scan enable falls, capture mode begins. The fall is first carried into the clock's own domain through a two-stage synchronizer. The synchronized fall then loads a programmable shift register, and the low bit of that register drives the enable of a glitch-free clock gate.

Each bit of the programmed pattern stands for one clock slot. Bit 0 is the first slot after the synchronizer delay, so a pattern supplies the launch pulse, the capture pulse and any extra pulses at chosen positions. The pattern is sampled only while the synchronized scan enable is high. Once the pattern has shifted out, the gate stays closed until scan enable has been high again and then falls again. Each capture window therefore yields one burst.

Top module: `capture_pulse_filter`

## Requirements
- R1: While rst_n is low, gclk is low at all times. After reset is released with scan_en high, gclk stays low.
- R2: While scan_en is high and stays high, gclk produces no rising edge for any pattern value.
- R3: scan_en passes through a two-flop synchronizer. Number the rising clk edges after a falling scan_en as 1, 2, 3 and so on. The earliest gated pulse can then occur at edge 4.
- R4: After a falling scan_en, gclk pulses at edge 4+i exactly when pattern bit i is 1, for i = 0 to PAT_W-1, with bit 0 first. The number of gated pulses therefore equals the number of 1 bits in the pattern.
- R5: While scan_en stays low after the burst, no further gated pulse occurs. Each capture window gives exactly one burst.
- R6: The pattern is captured while the synchronized scan enable is high. A pattern change made after edge 3 of a capture window has no effect on that burst, and it is used by the next capture window.
- R7: gclk is low during every low phase of clk. Every gated pulse is high across the whole high phase of its clk cycle.
- R8: Asserting rst_n low in the middle of a burst forces gclk low at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock of the filtered domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Scan enable; high selects shift mode, low selects capture mode |
| pattern | input | PAT_W | Pulse slot pattern; bit i enables slot i of the burst |
| gclk | output | 1 | Gated clock carrying the burst |

## Verification
The hardest behaviour to show from the ports is that a pattern change made in the middle of a capture window is ignored and that the new value takes effect in the next window. Reaching that case means changing the pattern only after the synchronized scan enable has gone low. The stimulus therefore drops scan_en on a falling clock edge, counts rising edges and changes the pattern after edge 3. It then runs a second window. Edge positions are checked by sampling gclk within each high phase and each low phase, so a pulse that lands one slot late, or a shortened pulse, shows up as a mismatch.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  // clk edge, counted from a falling scan_en, at which slot 0 can pulse:
  // the synchronizer stages, then one edge to load the register and one
  // edge at which the latched enable opens the gate
  function automatic int first_slot_edge(input int sync_stages);
    return sync_stages + 2;
  endfunction

  // falling edge of the synchronized scan enable
  function automatic logic capture_edge(input logic prev_q, input logic now_q);
    return prev_q & ~now_q;
  endfunction
endpackage

// File: rtl/cpf_sync.sv
module cpf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cpf_shifter.sv
module cpf_shifter
  import cpf_pkg::*;
#(
  parameter int PAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se_synced,
  input  logic [PAT_W-1:0] pattern,
  output logic             burst_start,
  output logic             gate_en,
  output logic [PAT_W-1:0] shift_q,
  output logic [PAT_W-1:0] pat_hold
);
  logic se_prev;

  assign burst_start = capture_edge(se_prev, se_synced);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_prev  <= 1'b0;
      pat_hold <= '0;
      shift_q  <= '0;
    end else begin
      se_prev <= se_synced;
      if (se_synced) pat_hold <= pattern;
      if (se_synced)        shift_q <= '0;
      else if (burst_start) shift_q <= pat_hold;
      else                  shift_q <= shift_q >> 1;
    end
  end

  assign gate_en = shift_q[0];
endmodule

// File: rtl/cpf_clock_gate.sv
module cpf_clock_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // transparent while clk is low, so the enable is frozen for a whole high phase
  always_latch begin
    if (!rst_n)   en_lat = 1'b0;
    else if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat & rst_n;
endmodule

// File: rtl/capture_pulse_filter.sv
module capture_pulse_filter #(
  parameter int PAT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic [PAT_W-1:0] pattern,
  output logic             gclk
);
  logic             se_synced;
  logic             burst_start;
  logic             gate_en;
  logic [PAT_W-1:0] shift_q;
  logic [PAT_W-1:0] pat_hold;

  cpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scan_en),
    .q     (se_synced)
  );

  cpf_shifter #(.PAT_W(PAT_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .se_synced   (se_synced),
    .pattern     (pattern),
    .burst_start (burst_start),
    .gate_en     (gate_en),
    .shift_q     (shift_q),
    .pat_hold    (pat_hold)
  );

  cpf_clock_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (gate_en),
    .gclk  (gclk)
  );
endmodule

// File: rtl/cpf_checker.sv
module cpf_checker #(
  parameter int PAT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_en,
  input logic             se_synced,
  input logic             burst_start,
  input logic             gate_en,
  input logic [PAT_W-1:0] shift_q,
  input logic [PAT_W-1:0] pat_hold,
  input logic             gclk
);
  // R1
  always_comb begin
    if (!rst_n) gclk_reset_chk: assert (!gclk);
  end

  // R2
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    se_synced |=> (shift_q == '0));

  // R3
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(se_synced) |-> !$past(scan_en, 2));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (shift_q == $past(pat_hold)));

  // R4
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!se_synced && !burst_start) |=> (shift_q == ($past(shift_q) >> 1)));

  // R5
  single_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!se_synced && !burst_start && shift_q == '0) |=> !gate_en);

  // R6
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !se_synced |=> $stable(pat_hold));
endmodule

bind capture_pulse_filter cpf_checker #(.PAT_W(PAT_W)) u_chk (.*);

// File: tb/capture_pulse_filter_tb.sv
`timescale 1ns/1ps
module capture_pulse_filter_tb;
  localparam int PAT_W = 4;
  localparam int FIRST = 4;
  localparam int NVEC  = 7;
  localparam int WIN   = 14;

  // pattern, expected pulse count, expected first pulse edge (0 = none)
  localparam logic [PAT_W-1:0] VPAT   [NVEC] = '{4'b0011, 4'b1111, 4'b0101, 4'b1000, 4'b0000, 4'b1001, 4'b0110};
  localparam int               VCOUNT [NVEC] = '{2, 4, 2, 1, 0, 2, 2};
  localparam int               VFIRST [NVEC] = '{4, 4, 4, 7, 0, 4, 5};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scan_en = 1'b1;
  logic [PAT_W-1:0] pattern = '0;
  logic             gclk;

  int checks = 0;
  int failures = 0;

  capture_pulse_filter #(.PAT_W(PAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .pattern(pattern), .gclk(gclk)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drops scan_en on a falling edge, records gclk in each high phase of
  // edges 1..WIN, and counts low-phase samples that see gclk high
  task automatic capture(output logic [WIN:1] mask, output int low_bad,
                         input logic [PAT_W-1:0] late_pat, input logic do_late);
    mask = '0;
    low_bad = 0;
    @(negedge clk);
    scan_en = 1'b0;
    for (int k = 1; k <= WIN; k++) begin
      @(posedge clk); #1;
      mask[k] = gclk;
      @(negedge clk); #1;
      if (gclk) low_bad++;
      if (do_late && k == 3) pattern = late_pat;
    end
    scan_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [WIN:1] expect_mask(input logic [PAT_W-1:0] p);
    logic [WIN:1] m = '0;
    for (int i = 0; i < PAT_W; i++) m[FIRST+i] = p[i];
    return m;
  endfunction

  function automatic int first_of(input logic [WIN:1] m);
    for (int k = 1; k <= WIN; k++) if (m[k]) return k;
    return 0;
  endfunction

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [WIN:1] m;
    int lb;
    int hi;

    // R1: reset holds gclk low while scan_en toggles
    hi = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); scan_en = k[1]; pattern = 4'b1111;
      @(posedge clk); #1; if (gclk) hi++;
    end
    check("R1 reset", hi, 0);
    @(negedge clk); scan_en = 1'b1; rst_n = 1'b1;

    // R2: shift mode, no pulses
    hi = 0;
    for (int k = 0; k < 20; k++) begin @(posedge clk); #1; if (gclk) hi++; end
    check("R2 shift idle", hi, 0);

    // table of vectors: R3, R4, R5, R7
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk); pattern = VPAT[v];
      repeat (4) @(negedge clk);
      capture(m, lb, '0, 1'b0);
      check("R4 count", $countones(m), VCOUNT[v]);
      check("R3 first edge", first_of(m), VFIRST[v]);
      check("R4 slot mask", int'(m), int'(expect_mask(VPAT[v])));
      check("R5 no pulse after burst", int'(m[WIN:FIRST+PAT_W]), 0);
      check("R7 low phase clean", lb, 0);
    end

    // R6: change during capture ignored, then used next window
    @(negedge clk); pattern = 4'b0011;
    repeat (4) @(negedge clk);
    capture(m, lb, 4'b1100, 1'b1);
    check("R6 late change ignored", int'(m), int'(expect_mask(4'b0011)));
    capture(m, lb, '0, 1'b0);
    check("R6 next window uses new", int'(m), int'(expect_mask(4'b1100)));

    // R8: reset in mid burst forces gclk low
    @(negedge clk); pattern = 4'b1111;
    repeat (4) @(negedge clk);
    @(negedge clk); scan_en = 1'b0;
    repeat (4) @(posedge clk);
    #1; check("R8 pulse before reset", int'(gclk), 1);
    #0.5; rst_n = 1'b0;
    #0.2; check("R8 gclk low on reset", int'(gclk), 0);
    @(posedge clk); #1; check("R8 stays low", int'(gclk), 0);
    @(negedge clk); scan_en = 1'b1; rst_n = 1'b1;
    hi = 0;
    for (int k = 0; k < 10; k++) begin @(posedge clk); #1; if (gclk) hi++; end
    check("R1 after release with scan_en high", hi, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule